// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block runs one pass of a block-transfer instruction: a memory-to-memory copy, a compare-search against an accumulator, a port-to-memory input, or a memory-to-port output. It holds two 16-bit pointers (HL as the source or memory pointer, DE as the copy destination), a 16-bit count pair BC, the accumulator A and a flag byte. It moves the pointers up or down and counts BC or only its upper byte B down. It then rewrites the flags and says whether the instruction has to run again.

A controller first loads the registers while the sequencer is idle. It then pulses `start` with the operation, the direction and the repeat mode. The sequencer makes its accesses on a request/acknowledge memory port and on an I/O port whose address is the BC pair. When the last access is acknowledged it pulses `done` and presents `repeat_o` together with a cycle-penalty value. A repeat stands in for stepping the program counter back. The controller answers a repeat by starting the same pass again.

Top module: `blkseq_top`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `done`, `repeat_o`, `mem_req` and `io_req` are 0, and HL, DE, BC and the flag byte read 0.
- R2: `ld_en` in idle loads HL, DE, BC, A and flags, and wins over `start` in the same cycle. While busy, both `ld_en` and `start` are ignored.
- R3: Copy (op 0) reads a byte at HL and writes it at DE. Both pointers then step by +1 (`down_i`=0) or -1 (`down_i`=1), and the 16-bit BC decrements.
- R4: Flag bits are S=7, Z=6, H=4, PV=2, N=1 and C=0. Copy clears H, PV and N and keeps the other bits. It then sets PV when the new BC is nonzero.
- R5: Search (op 1) reads the byte at HL, steps HL, decrements BC and leaves DE alone. The flags are set as follows:
  - C is kept.
  - S is bit 7 of A minus the byte, and Z is set when that difference is zero.
  - H is bit 4 of (difference xor A xor byte).
  - PV is set when the new BC is nonzero.
  - Bits 5 and 3 are 0.
  - N is 1 in single mode. In repeat mode N is 1 only on a match.
- R6: Port input (op 2) reads the port at address BC and writes that byte at HL. HL steps, only B decrements and C is kept. The flags become 0x02, or 0x42 when the new B is 0.
- R7: Port output (op 3) reads memory at HL and steps HL. It then writes the byte to the port at address {B-1, C}. B decrements and the flags are set as in R6.
- R8: `repeat_o` is 1 with `done` only in repeat mode. For copy the new BC must be nonzero. For search the new BC must be nonzero and there must be no match. For port input and output the new B must be nonzero.
- R9: `penalty_o` is 5 when `repeat_o` is 1 and 0 otherwise.
- R10: A request is held with a stable address until it is acknowledged, and memory and I/O are never requested together. `done` is a one-cycle pulse in the cycle after the last acknowledge.
- R11: The counters wrap: a copy with BC=0 leaves BC=0xFFFF and sets PV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load registers (idle only) |
| ld_hl | input | 16 | Load value for HL |
| ld_de | input | 16 | Load value for DE |
| ld_bc | input | 16 | Load value for BC |
| ld_acc | input | 8 | Load value for A |
| ld_flags | input | 8 | Load value for flags |
| start | input | 1 | Begin one pass (idle only) |
| op_i | input | 2 | 0 copy, 1 search, 2 port in, 3 port out |
| down_i | input | 1 | 1 = pointers decrement |
| rep_i | input | 1 | Repeat mode |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data |
| io_req | output | 1 | Port request |
| io_we | output | 1 | Port write |
| io_addr | output | 16 | Port address |
| io_wdata | output | 8 | Port write data |
| io_ack | input | 1 | Port acknowledge |
| io_rdata | input | 8 | Port read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass complete pulse |
| repeat_o | output | 1 | Pass must be reissued |
| penalty_o | output | 3 | Extra cycles for a repeat |
| hl_o | output | 16 | HL value |
| de_o | output | 16 | DE value |
| bc_o | output | 16 | BC value |
| flags_o | output | 8 | Flag byte |

## Verification
Several rules are checked on every cycle by the assertions:
- the two ports are never requested together, and nothing is requested while idle;
- a request and its address stay put until acknowledged;
- `done` lasts one cycle and is followed by idle;
- the penalty agrees with `repeat_o`, and single mode never repeats;
- after copy, PV agrees with BC; after port transfers, the flags agree with B.

Only the bench's scenarios can show the data path. These cover the exact byte moved and its addresses, the step direction, the search flag arithmetic, and a search run that stops early on a match. They also cover the late B value appearing in the output port address, BC wrap-around, and loads or starts ignored while busy.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

    typedef enum logic [1:0] {
        OP_COPY     = 2'd0,
        OP_SEARCH   = 2'd1,
        OP_PORT_IN  = 2'd2,
        OP_PORT_OUT = 2'd3
    } blk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } blk_st_e;

    localparam int FLAG_W  = 8;
    localparam int FLAG_C  = 0;
    localparam int FLAG_N  = 1;
    localparam int FLAG_PV = 2;
    localparam int FLAG_H  = 4;
    localparam int FLAG_Z  = 6;
    localparam int FLAG_S  = 7;

endpackage

// File: rtl/blkseq_step.sv
module blkseq_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic         down,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (down) nxt = ptr - W'(1);
        else      nxt = ptr + W'(1);
    end
endmodule

// File: rtl/blkseq_flags.sv
module blkseq_flags
    import blkseq_pkg::*;
#(
    parameter int DW = 8
) (
    input  blk_op_e             op,
    input  logic                rep,
    input  logic [FLAG_W-1:0]   f_in,
    input  logic [DW-1:0]       acc,
    input  logic [DW-1:0]       byte_in,
    input  logic                cnt_nz,
    input  logic                hi_nz,
    output logic [FLAG_W-1:0]   f_out,
    output logic                again
);
    localparam int HB = DW / 2;

    logic [DW-1:0] diff;
    logic [DW-1:0] carry_vec;
    logic          match;

    always_comb begin
        diff      = acc - byte_in;
        carry_vec = diff ^ acc ^ byte_in;
        match     = (diff == '0);
        f_out     = '0;
        again     = 1'b0;
        case (op)
            OP_COPY: begin
                f_out          = f_in;
                f_out[FLAG_H]  = 1'b0;
                f_out[FLAG_N]  = 1'b0;
                f_out[FLAG_PV] = cnt_nz;
                again          = rep && cnt_nz;
            end
            OP_SEARCH: begin
                f_out[FLAG_C]  = f_in[FLAG_C];
                f_out[FLAG_S]  = diff[DW-1];
                f_out[FLAG_Z]  = match;
                f_out[FLAG_H]  = carry_vec[HB];
                f_out[FLAG_PV] = cnt_nz;
                f_out[FLAG_N]  = !rep || match;
                again          = rep && !match && cnt_nz;
            end
            default: begin
                f_out[FLAG_N]  = 1'b1;
                f_out[FLAG_Z]  = !hi_nz;
                again          = rep && hi_nz;
            end
        endcase
    end
endmodule

// File: rtl/blkseq_ctrl.sv
module blkseq_ctrl
    import blkseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  blk_op_e op,
    input  logic    mem_ack,
    input  logic    io_ack,
    output blk_st_e st,
    output logic    rd_hit,
    output logic    last_hit
);
    blk_st_e st_d, st_q;
    logic    rd_ack, wr_ack, wr_hit;

    always_comb begin
        rd_ack   = (op == OP_PORT_IN)  ? io_ack : mem_ack;
        wr_ack   = (op == OP_PORT_OUT) ? io_ack : mem_ack;
        rd_hit   = (st_q == ST_READ)  && rd_ack;
        wr_hit   = (st_q == ST_WRITE) && wr_ack;
        last_hit = wr_hit || (rd_hit && op == OP_SEARCH);
        st_d     = st_q;
        case (st_q)
            ST_IDLE:   if (start) st_d = ST_READ;
            ST_READ:   if (rd_hit) st_d = (op == OP_SEARCH) ? ST_FINISH : ST_WRITE;
            ST_WRITE:  if (wr_hit) st_d = ST_FINISH;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign st = st_q;

    AST_FINISH_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_FINISH |=> st_q == ST_IDLE); // R10
    AST_SEARCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_WRITE |-> op != OP_SEARCH); // R5
endmodule

// File: rtl/blkseq_top.sv
module blkseq_top
    import blkseq_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PENALTY = 5,
    localparam int AW     = 2 * DW,
    localparam int PW     = $clog2(PENALTY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_hl,
    input  logic [AW-1:0]     ld_de,
    input  logic [AW-1:0]     ld_bc,
    input  logic [DW-1:0]     ld_acc,
    input  logic [FLAG_W-1:0] ld_flags,
    input  logic              start,
    input  logic [1:0]        op_i,
    input  logic              down_i,
    input  logic              rep_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              io_req,
    output logic              io_we,
    output logic [AW-1:0]     io_addr,
    output logic [DW-1:0]     io_wdata,
    input  logic              io_ack,
    input  logic [DW-1:0]     io_rdata,
    output logic              busy,
    output logic              done,
    output logic              repeat_o,
    output logic [PW-1:0]     penalty_o,
    output logic [AW-1:0]     hl_o,
    output logic [AW-1:0]     de_o,
    output logic [AW-1:0]     bc_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [AW-1:0]     hl;
        logic [AW-1:0]     de;
        logic [AW-1:0]     bc;
        logic [DW-1:0]     acc;
        logic [DW-1:0]     data;
        logic [FLAG_W-1:0] f;
        logic              again;
        blk_op_e           op;
        logic              down;
        logic              rep;
    } regs_t;

    regs_t r_d, r_q;

    blk_st_e           st;
    logic              rd_hit, last_hit;
    logic [AW-1:0]     hl_nx, de_nx, bc_dec;
    logic [DW-1:0]     b_dec, rd_byte;
    logic [FLAG_W-1:0] f_new;
    logic              again_new, wide_cnt, go;

    assign go = start && !ld_en;

    blkseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .op       (r_q.op),
        .mem_ack  (mem_ack),
        .io_ack   (io_ack),
        .st       (st),
        .rd_hit   (rd_hit),
        .last_hit (last_hit)
    );

    blkseq_step #(.W(AW)) u_step_hl (.ptr(r_q.hl), .down(r_q.down), .nxt(hl_nx));
    blkseq_step #(.W(AW)) u_step_de (.ptr(r_q.de), .down(r_q.down), .nxt(de_nx));

    assign bc_dec   = r_q.bc - AW'(1);
    assign b_dec    = r_q.bc[AW-1:DW] - DW'(1);
    assign wide_cnt = (r_q.op == OP_COPY) || (r_q.op == OP_SEARCH);
    assign rd_byte  = (r_q.op == OP_PORT_IN) ? io_rdata : mem_rdata;

    blkseq_flags #(.DW(DW)) u_flags (
        .op      (r_q.op),
        .rep     (r_q.rep),
        .f_in    (r_q.f),
        .acc     (r_q.acc),
        .byte_in (rd_byte),
        .cnt_nz  (bc_dec != '0),
        .hi_nz   (b_dec != '0),
        .f_out   (f_new),
        .again   (again_new)
    );

    always_comb begin
        r_d = r_q;
        if (st == ST_IDLE && ld_en) begin
            r_d.hl  = ld_hl;
            r_d.de  = ld_de;
            r_d.bc  = ld_bc;
            r_d.acc = ld_acc;
            r_d.f   = ld_flags;
        end
        if (st == ST_IDLE && go) begin
            r_d.op    = blk_op_e'(op_i);
            r_d.down  = down_i;
            r_d.rep   = rep_i;
            r_d.again = 1'b0;
        end
        if (rd_hit) r_d.data = rd_byte;
        if (last_hit) begin
            r_d.hl = hl_nx;
            if (r_q.op == OP_COPY) r_d.de = de_nx;
            if (wide_cnt) r_d.bc = bc_dec;
            else          r_d.bc = {b_dec, r_q.bc[DW-1:0]};
            r_d.f     = f_new;
            r_d.again = again_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req = ((st == ST_READ)  && (r_q.op != OP_PORT_IN)) ||
                  ((st == ST_WRITE) && (r_q.op == OP_COPY || r_q.op == OP_PORT_IN));
        io_req  = ((st == ST_READ)  && (r_q.op == OP_PORT_IN)) ||
                  ((st == ST_WRITE) && (r_q.op == OP_PORT_OUT));
        mem_we  = mem_req && (st == ST_WRITE);
        io_we   = io_req  && (st == ST_WRITE);
        mem_addr = (st == ST_WRITE && r_q.op == OP_COPY) ? r_q.de : r_q.hl;
        io_addr  = (st == ST_WRITE) ? {b_dec, r_q.bc[DW-1:0]} : r_q.bc;
    end

    assign mem_wdata = r_q.data;
    assign io_wdata  = r_q.data;
    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_FINISH);
    assign repeat_o  = done && r_q.again;
    assign penalty_o = repeat_o ? PW'(PENALTY) : '0;
    assign hl_o      = r_q.hl;
    assign de_o      = r_q.de;
    assign bc_o      = r_q.bc;
    assign flags_o   = r_q.f;

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && io_req)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !io_req); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
    AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_we)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
        penalty_o == (repeat_o ? PW'(PENALTY) : PW'(0))); // R9
    AST_SINGLE_NOREP: assert property (@(posedge clk) disable iff (!rst_n)
        done && !r_q.rep |-> !repeat_o); // R8
    AST_COPY_PV: assert property (@(posedge clk) disable iff (!rst_n)
        done && r_q.op == OP_COPY |-> flags_o[FLAG_PV] == (bc_o != '0)); // R4
    AST_PORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !wide_cnt |-> flags_o == ((FLAG_W'(1) << FLAG_N) |
            ((bc_o[AW-1:DW] == '0) ? (FLAG_W'(1) << FLAG_Z) : FLAG_W'(0)))); // R6
endmodule

// File: tb/test_blkseq_top.sv
`timescale 1ns/1ps
module test_blkseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_hl = '0, ld_de = '0, ld_bc = '0;
    logic [7:0]  ld_acc = '0, ld_flags = '0;
    logic        start = 1'b0;
    logic [1:0]  op_i = '0;
    logic        down_i = 1'b0, rep_i = 1'b0;
    logic        mem_req, mem_we, io_req, io_we, mem_ack = 1'b0, io_ack = 1'b0;
    logic [15:0] mem_addr, io_addr;
    logic [7:0]  mem_wdata, io_wdata, mem_rdata = '0, io_rdata = '0;
    logic        busy, done, repeat_o;
    logic [2:0]  penalty_o;
    logic [15:0] hl_o, de_o, bc_o;
    logic [7:0]  flags_o;

    always #2 clk = ~clk;

    blkseq_top i_blkseq_top (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hl(ld_hl), .ld_de(ld_de),
        .ld_bc(ld_bc), .ld_acc(ld_acc), .ld_flags(ld_flags), .start(start),
        .op_i(op_i), .down_i(down_i), .rep_i(rep_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata),
        .busy(busy), .done(done), .repeat_o(repeat_o), .penalty_o(penalty_o),
        .hl_o(hl_o), .de_o(de_o), .bc_o(bc_o), .flags_o(flags_o)
    );

    int tests = 0, fails = 0;
    bit fin = 0;
    logic [7:0] mem [int];
    int m_hl, m_de, m_bc, m_a, m_f;
    bit last_rep;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int mem_peek(int a);
        if (mem.exists(a)) return int'(mem[a]);
        return (a * 7 + 3) & 8'hFF;
    endfunction

    function automatic int io_val(int a);
        return (a & 8'hFF) ^ ((a >> 8) & 8'hFF) ^ 8'h5A;
    endfunction

    function automatic int step(int x, bit dn);
        return dn ? ((x - 1) & 16'hFFFF) : ((x + 1) & 16'hFFFF);
    endfunction

    task automatic load(int hl, int de, int bc, int a, int f);
        @(negedge clk);
        ld_en = 1; ld_hl = 16'(hl); ld_de = 16'(de); ld_bc = 16'(bc);
        ld_acc = 8'(a); ld_flags = 8'(f);
        @(negedge clk);
        ld_en = 0;
        m_hl = hl; m_de = de; m_bc = bc; m_a = a; m_f = f;
        check("R2 load hl", int'(hl_o), hl);
        check("R2 load bc", int'(bc_o), bc);
    endtask

    task automatic do_op(int op, bit dn, bit rep, int waits, bit poke);
        int rb, nhl, nde, nbc, nb, nf, d, n, idx, wc, cyc;
        bit rpt;
        bit e_io[2]; bit e_we[2]; int e_addr[2]; int e_wd[2];
        string tag;
        nhl = step(m_hl, dn); nde = m_de; rpt = 0;
        nb = ((m_bc >> 8) - 1) & 8'hFF;
        case (op)
            0: begin
                tag = "R3 R4"; rb = mem_peek(m_hl); n = 2;
                e_io[0] = 0; e_we[0] = 0; e_addr[0] = m_hl;
                e_io[1] = 0; e_we[1] = 1; e_addr[1] = m_de; e_wd[1] = rb;
                nbc = (m_bc - 1) & 16'hFFFF; nde = step(m_de, dn);
                nf = (m_f & 8'hE9) | ((nbc != 0) ? 4 : 0);
                rpt = rep && nbc != 0;
            end
            1: begin
                tag = "R5"; rb = mem_peek(m_hl); n = 1;
                e_io[0] = 0; e_we[0] = 0; e_addr[0] = m_hl;
                nbc = (m_bc - 1) & 16'hFFFF;
                d = (m_a - rb) & 8'hFF;
                nf = (m_f & 1) | (d & 8'h80) | ((d == 0) ? 8'h40 : 0) |
                     ((d ^ m_a ^ rb) & 8'h10) | ((nbc != 0) ? 4 : 0);
                if (!rep || d == 0) nf |= 2;
                rpt = rep && d != 0 && nbc != 0;
            end
            2: begin
                tag = "R6"; rb = io_val(m_bc); n = 2;
                e_io[0] = 1; e_we[0] = 0; e_addr[0] = m_bc;
                e_io[1] = 0; e_we[1] = 1; e_addr[1] = m_hl; e_wd[1] = rb;
                nbc = (nb << 8) | (m_bc & 8'hFF);
                nf = 2 | ((nb == 0) ? 8'h40 : 0); rpt = rep && nb != 0;
            end
            default: begin
                tag = "R7"; rb = mem_peek(m_hl); n = 2;
                nbc = (nb << 8) | (m_bc & 8'hFF);
                e_io[0] = 0; e_we[0] = 0; e_addr[0] = m_hl;
                e_io[1] = 1; e_we[1] = 1; e_addr[1] = nbc; e_wd[1] = rb;
                nf = 2 | ((nb == 0) ? 8'h40 : 0); rpt = rep && nb != 0;
            end
        endcase
        @(negedge clk);
        op_i = 2'(op); down_i = dn; rep_i = rep; start = 1;
        idx = 0; wc = 0; cyc = 0;
        while (cyc < 200) begin
            @(negedge clk);
            start = 0; ld_en = 0; mem_ack = 0; io_ack = 0;
            if (poke && cyc == 0) begin
                ld_en = 1; ld_hl = 16'h1111; ld_bc = 16'h2222; start = 1;
            end
            cyc++;
            if (done) break;
            if (mem_req || io_req) begin
                if (idx >= n) begin
                    check({tag, " R10 extra access"}, idx, n - 1);
                end else begin
                    if (wc == 0) begin
                        check({tag, " port kind"}, int'(io_req), int'(e_io[idx]));
                        check({tag, " addr"}, e_io[idx] ? int'(io_addr) : int'(mem_addr), e_addr[idx]);
                        check({tag, " we"}, e_io[idx] ? int'(io_we) : int'(mem_we), int'(e_we[idx]));
                        if (e_we[idx])
                            check({tag, " wdata"}, e_io[idx] ? int'(io_wdata) : int'(mem_wdata), e_wd[idx]);
                    end else begin
                        check("R10 held addr", e_io[idx] ? int'(io_addr) : int'(mem_addr), e_addr[idx]);
                    end
                    if (wc < waits) wc++;
                    else begin
                        if (e_io[idx]) begin io_ack = 1; io_rdata = 8'(io_val(e_addr[idx])); end
                        else begin mem_ack = 1; mem_rdata = 8'(mem_peek(e_addr[idx])); end
                        if (e_we[idx] && !e_io[idx]) mem[e_addr[idx]] = 8'(e_wd[idx]);
                        idx++; wc = 0;
                    end
                end
            end
        end
        check({tag, " R10 done reached"}, int'(done), 1);
        check({tag, " R10 all accesses"}, idx, n);
        check({tag, " hl"}, int'(hl_o), nhl);
        check({tag, " de"}, int'(de_o), nde);
        check({tag, " bc"}, int'(bc_o), nbc);
        check({tag, " flags"}, int'(flags_o), nf);
        check("R8 repeat", int'(repeat_o), int'(rpt));
        check("R9 penalty", int'(penalty_o), rpt ? 5 : 0);
        m_hl = nhl; m_de = nde; m_bc = nbc; m_f = nf; last_rep = rpt;
        @(negedge clk);
        check("R10 done pulse", int'(done), 0);
        check("R10 idle after", int'(busy), 0);
    endtask

    task automatic run_rep(int op, bit dn, int waits, int max_it, output int iters);
        iters = 0;
        do begin
            do_op(op, dn, 1, waits, 0);
            iters++;
        end while (last_rep && iters < max_it);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int it;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 reqs", int'({mem_req, io_req, repeat_o}), 0);
        check("R1 regs", int'(hl_o | de_o | bc_o), 0);
        check("R1 flags", int'(flags_o), 0);
        rst_n = 1;
        @(negedge clk);

        // R2 load wins over start in the same cycle
        @(negedge clk);
        ld_en = 1; start = 1; ld_hl = 16'h0100; ld_de = 16'h0400; ld_bc = 16'h0003;
        ld_acc = 8'h00; ld_flags = 8'hFF;
        @(negedge clk);
        ld_en = 0; start = 0;
        m_hl = 16'h0100; m_de = 16'h0400; m_bc = 3; m_a = 0; m_f = 8'hFF;
        check("R2 start ignored under load", int'(busy), 0);
        check("R2 loaded de", int'(de_o), 16'h0400);

        do_op(0, 0, 0, 0, 0);            // R3 R4 copy up
        do_op(0, 1, 0, 2, 0);            // R3 copy down with waits
        load(16'h0120, 16'h0500, 16'h0001, 0, 8'h16);
        do_op(0, 0, 0, 1, 0);            // R4 PV clear at BC end
        load(16'h0130, 16'h0510, 16'h0000, 0, 8'h00);
        do_op(0, 0, 0, 0, 0);            // R11 wrap
        check("R11 bc wrap", int'(bc_o), 16'hFFFF);
        load(16'h0140, 16'h0600, 16'h0004, 0, 8'h00);
        run_rep(0, 0, 1, 20, it);        // R8 copy run
        check("R8 copy iterations", it, 4);
        check("R3 copied byte", mem_peek(16'h0603), mem_peek(16'h0143));

        load(16'h0200, 16'h0000, 16'h0010, 8'h00, 8'h01);
        do_op(1, 0, 0, 0, 0);            // R5 single mismatch
        load(16'h0210, 16'h0000, 16'h0010, mem_peek(16'h0210), 8'h00);
        do_op(1, 1, 0, 0, 0);            // R5 single match
        load(16'h0220, 16'h0000, 16'h000A, mem_peek(16'h0223), 8'h01);
        run_rep(1, 0, 0, 20, it);        // R5 R8 stop on match
        check("R5 match stop iterations", it, 4);
        load(16'h0300, 16'h0000, 16'h0003, mem_peek(16'h0364), 8'h00);
        run_rep(1, 0, 1, 20, it);        // R8 stop on BC end
        check("R8 search iterations", it, 3);

        load(16'h0700, 16'h0000, 16'h0145, 0, 8'hFF);
        do_op(2, 0, 0, 0, 0);            // R6 single
        load(16'h0710, 16'h0000, 16'h0377, 0, 8'h00);
        run_rep(2, 1, 1, 20, it);        // R6 R8 input run
        check("R6 input iterations", it, 3);
        check("R6 stored byte", mem_peek(16'h070E), io_val(16'h0177));

        load(16'h0800, 16'h0000, 16'h0122, 0, 8'h00);
        do_op(3, 0, 0, 2, 0);            // R7 single, B to 0
        load(16'h0810, 16'h0000, 16'h0233, 0, 8'h00);
        run_rep(3, 0, 0, 20, it);        // R7 R8 output run
        check("R7 output iterations", it, 2);

        load(16'h0900, 16'h0A00, 16'h0005, 0, 8'h00);
        do_op(0, 0, 0, 1, 1);            // R2 load/start ignored while busy
        check("R2 busy load ignored", int'(hl_o), 16'h0901);

        fin = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule